// File: doc/BRIEF.md
# Wake-up event status router

This block gathers single-cycle wake-up event pulses (keyboard or mouse sequence match, modem ring, general-purpose input edge, module interrupt and similar) and keeps one sticky status bit per event. An event sets its status bit only when at least one of three detection-enable masks has that event's bit set. Once set, a status bit stays set until software clears it by writing a one to it.

Four wake outputs are derived from the status bits: a system-management interrupt line, an ordinary interrupt line, a power-up request and a power-button output. Each output has its own routing mask. An output is high while any status bit with its routing bit set is high, so one event can drive several outputs at once. Software reaches all registers through a byte-wide port. Events are grouped into banks of eight, and each bank has eight registers.

Top module: `wk_event_router`

## Requirements
- R1: While reset is low, and at the first read after reset, every status, enable and routing register reads 0x00 and all four wake outputs are low.
- R2: A pulse on event i sets status bit i at the next clock edge when any one of the three detection-enable bits for that event is set. Any single one of the three is enough.
- R3: A pulse on an event whose three detection-enable bits are all clear is ignored, and its status bit stays 0.
- R4: A status bit stays set after the event pulse ends, with no limit on how many cycles pass.
- R5: Writing a 1 to a status bit position clears that bit. Writing a 0 leaves the bit unchanged.
- R6: When an event pulse and a clearing write hit the same status bit in the same cycle, and the event is enabled, the bit ends set.
- R7: Each wake output equals the OR over all events of (status AND that output's routing bit). It goes high in the cycle after the clock edge that captured the pulse.
- R8: An event whose bit is set in several routing masks drives all of those outputs at once, and leaves the other outputs low.
- R9: An output stays high until every status bit that contributes to it has been cleared.
- R10: Register address = bank*8 + kind. The kinds are: 0 status, 1/2/3 detection enables A/B/C, 4 management-interrupt route, 5 interrupt route, 6 power-up route, 7 power-button route. Event i lives in bank i/8 at bit i%8. Enable and routing registers read back the value written.
- R11: A set status bit whose event has no routing bit set drives no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_pulse | input | NUM_EVT | One-cycle event pulses, one bit per event |
| reg_addr | input | ADDR_W | Register address, {bank, kind} |
| reg_wr | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | EVT_PER_BANK | Write data |
| reg_rdata | output | EVT_PER_BANK | Read data of the addressed register (combinational) |
| wake_smi | output | 1 | Management-interrupt wake output |
| wake_irq | output | 1 | Interrupt wake output |
| wake_pwrup | output | 1 | Power-up request output |
| wake_pwrbtn | output | 1 | Power-button wake output |

## Verification
The bench drives the collision of an event pulse with a clearing write to the same bit. A design that gives the clear priority would lose a wake-up that arrived during service. Each of the three enable masks is enabled on its own, which exposes a design that ANDs the masks or wires up only one of them. The bench also writes zero to a set status bit, which catches a design that treats the write as a load rather than a clear. It holds one output with two sources and clears them one at a time, so an output that drops after the first clear is reported. An event in the upper bank is routed to two outputs to check both the bank mapping and the routing to several outputs.

// File: rtl/wk_pkg.sv
package wk_pkg;
    localparam int NUM_DET = 3;
    localparam int NUM_OUT = 4;
    localparam int KIND_W  = 3;

    typedef enum logic [KIND_W-1:0] {
        K_STS   = 3'd0,
        K_DET_A = 3'd1,
        K_DET_B = 3'd2,
        K_DET_C = 3'd3,
        K_R_SMI = 3'd4,
        K_R_IRQ = 3'd5,
        K_R_PUP = 3'd6,
        K_R_PBT = 3'd7
    } kind_e;

    localparam int OUT_SMI = 0;
    localparam int OUT_IRQ = 1;
    localparam int OUT_PUP = 2;
    localparam int OUT_PBT = 3;
endpackage

// File: rtl/wk_decode.sv
module wk_decode
    import wk_pkg::*;
#(
    parameter int NUM_EVT      = 16,
    parameter int EVT_PER_BANK = 8,
    parameter int BANK_W       = 1,
    parameter int ADDR_W       = KIND_W + BANK_W
) (
    input  logic [ADDR_W-1:0]       reg_addr,
    input  logic                    reg_wr,
    input  logic [EVT_PER_BANK-1:0] reg_wdata,
    output logic [NUM_EVT-1:0]      bank_hit,
    output logic [NUM_EVT-1:0]      wide_data,
    output kind_e                   kind
);
    logic [BANK_W-1:0] bank_sel;

    assign bank_sel = reg_addr[ADDR_W-1:KIND_W];
    assign kind     = kind_e'(reg_addr[KIND_W-1:0]);

    // spread the byte onto every event slot and mark the addressed bank
    for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
        assign bank_hit[i]  = reg_wr && (bank_sel == BANK_W'(i / EVT_PER_BANK));
        assign wide_data[i] = reg_wdata[i % EVT_PER_BANK];
    end
endmodule

// File: rtl/wk_regs.sv
module wk_regs
    import wk_pkg::*;
#(
    parameter int NUM_EVT = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_EVT-1:0]                evt_pulse,
    input  logic [NUM_EVT-1:0]                bank_hit,
    input  logic [NUM_EVT-1:0]                wide_data,
    input  kind_e                             kind,
    input  logic [NUM_EVT-1:0]                clr_mask,
    output logic [NUM_EVT-1:0]                sts_o,
    output logic [NUM_DET-1:0][NUM_EVT-1:0]   det_o,
    output logic [NUM_OUT-1:0][NUM_EVT-1:0]   rte_o,
    output logic [NUM_EVT-1:0]                det_any_o
);
    typedef struct packed {
        logic [NUM_EVT-1:0]              sts;
        logic [NUM_DET-1:0][NUM_EVT-1:0] det;
        logic [NUM_OUT-1:0][NUM_EVT-1:0] rte;
    } state_t;

    state_t st_d, st_q;
    logic [NUM_EVT-1:0] det_any;

    always_comb begin
        st_d    = st_q;
        det_any = '0;
        for (int k = 0; k < NUM_DET; k++) begin
            det_any = det_any | st_q.det[k];
        end
        // a new event wins over a clear of the same bit
        st_d.sts = (st_q.sts & ~clr_mask) | (evt_pulse & det_any);
        for (int k = 0; k < NUM_DET; k++) begin
            if (int'(kind) == int'(K_DET_A) + k) begin
                st_d.det[k] = (st_q.det[k] & ~bank_hit) | (wide_data & bank_hit);
            end
        end
        for (int o = 0; o < NUM_OUT; o++) begin
            if (int'(kind) == int'(K_R_SMI) + o) begin
                st_d.rte[o] = (st_q.rte[o] & ~bank_hit) | (wide_data & bank_hit);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sts_o     = st_q.sts;
    assign det_o     = st_q.det;
    assign rte_o     = st_q.rte;
    assign det_any_o = det_any;
endmodule

// File: rtl/wk_route.sv
module wk_route
    import wk_pkg::*;
#(
    parameter int NUM_EVT = 16
) (
    input  logic [NUM_EVT-1:0]              sts,
    input  logic [NUM_OUT-1:0][NUM_EVT-1:0] rte,
    output logic [NUM_OUT-1:0]              wake
);
    for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
        assign wake[o] = |(sts & rte[o]);
    end
endmodule

// File: rtl/wk_event_router.sv
module wk_event_router
    import wk_pkg::*;
#(
    parameter  int NUM_EVT      = 16,
    parameter  int EVT_PER_BANK = 8,
    localparam int NUM_BANKS    = (NUM_EVT + EVT_PER_BANK - 1) / EVT_PER_BANK,
    localparam int BANK_W       = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int ADDR_W       = KIND_W + BANK_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_EVT-1:0]      evt_pulse,
    input  logic [ADDR_W-1:0]       reg_addr,
    input  logic                    reg_wr,
    input  logic [EVT_PER_BANK-1:0] reg_wdata,
    output logic [EVT_PER_BANK-1:0] reg_rdata,
    output logic                    wake_smi,
    output logic                    wake_irq,
    output logic                    wake_pwrup,
    output logic                    wake_pwrbtn
);
    localparam int PAD_W = NUM_BANKS * EVT_PER_BANK;

    logic [NUM_EVT-1:0]              bank_hit;
    logic [NUM_EVT-1:0]              wide_data;
    kind_e                           kind;
    logic [NUM_EVT-1:0]              clr_mask;
    logic [NUM_EVT-1:0]              sts_q;
    logic [NUM_DET-1:0][NUM_EVT-1:0] det_q;
    logic [NUM_OUT-1:0][NUM_EVT-1:0] rte_q;
    logic [NUM_EVT-1:0]              det_any;
    logic [NUM_OUT-1:0]              wake;
    logic [PAD_W-1:0]                rd_vec;
    logic [BANK_W-1:0]               rd_bank;

    wk_decode #(
        .NUM_EVT(NUM_EVT), .EVT_PER_BANK(EVT_PER_BANK), .BANK_W(BANK_W), .ADDR_W(ADDR_W)
    ) u_dec (
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .bank_hit(bank_hit), .wide_data(wide_data), .kind(kind)
    );

    assign clr_mask = (kind == K_STS) ? (bank_hit & wide_data) : '0;

    wk_regs #(.NUM_EVT(NUM_EVT)) u_regs (
        .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse),
        .bank_hit(bank_hit), .wide_data(wide_data), .kind(kind), .clr_mask(clr_mask),
        .sts_o(sts_q), .det_o(det_q), .rte_o(rte_q), .det_any_o(det_any)
    );

    wk_route #(.NUM_EVT(NUM_EVT)) u_route (
        .sts(sts_q), .rte(rte_q), .wake(wake)
    );

    assign wake_smi    = wake[OUT_SMI];
    assign wake_irq    = wake[OUT_IRQ];
    assign wake_pwrup  = wake[OUT_PUP];
    assign wake_pwrbtn = wake[OUT_PBT];

    // read path: pick the register kind, then the addressed bank slice
    assign rd_bank = reg_addr[ADDR_W-1:KIND_W];

    always_comb begin
        rd_vec = '0;
        case (kind)
            K_STS:   rd_vec[NUM_EVT-1:0] = sts_q;
            K_DET_A: rd_vec[NUM_EVT-1:0] = det_q[0];
            K_DET_B: rd_vec[NUM_EVT-1:0] = det_q[1];
            K_DET_C: rd_vec[NUM_EVT-1:0] = det_q[2];
            K_R_SMI: rd_vec[NUM_EVT-1:0] = rte_q[OUT_SMI];
            K_R_IRQ: rd_vec[NUM_EVT-1:0] = rte_q[OUT_IRQ];
            K_R_PUP: rd_vec[NUM_EVT-1:0] = rte_q[OUT_PUP];
            K_R_PBT: rd_vec[NUM_EVT-1:0] = rte_q[OUT_PBT];
            default: rd_vec = '0;
        endcase
        reg_rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (int'(rd_bank) == b) begin
                reg_rdata = rd_vec[b*EVT_PER_BANK +: EVT_PER_BANK];
            end
        end
    end
endmodule

// File: rtl/wk_event_router_chk.sv
module wk_event_router_chk
    import wk_pkg::*;
#(
    parameter int NUM_EVT = 16
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic [NUM_EVT-1:0]                evt_pulse,
    input logic [NUM_EVT-1:0]                clr_mask,
    input logic [NUM_EVT-1:0]                det_any,
    input logic [NUM_EVT-1:0]                sts,
    input logic [NUM_OUT-1:0][NUM_EVT-1:0]   rte,
    input logic [NUM_OUT-1:0]                wake
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |-> (sts == '0 && wake == '0));

    assert_enabled_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_pulse & det_any) != '0) |=>
        ((sts & $past(evt_pulse & det_any)) == $past(evt_pulse & det_any)));

    assert_no_spurious_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((sts & ~$past(sts) & ~$past(evt_pulse & det_any)) == '0));

    assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((sts & $past(sts & ~clr_mask)) == $past(sts & ~clr_mask)));

    assert_collision_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_pulse & det_any & clr_mask) != '0) |=>
        ((sts & $past(evt_pulse & det_any & clr_mask)) == $past(evt_pulse & det_any & clr_mask)));

    for (genvar o = 0; o < NUM_OUT; o++) begin : g_rt
        assert_route_R7: assert property (@(posedge clk) disable iff (!rst_n)
            wake[o] == |(sts & rte[o]));
    end
endmodule

bind wk_event_router wk_event_router_chk #(.NUM_EVT(NUM_EVT)) u_chk (
    .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .clr_mask(clr_mask),
    .det_any(det_any), .sts(sts_q), .rte(rte_q), .wake(wake)
);

// File: tb/sim_wk_event_router.sv
module sim_wk_event_router;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] evt = '0;
    logic [3:0]  addr = '0;
    logic        wr = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        w_smi, w_irq, w_pup, w_pbt;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    wk_event_router u0 (
        .clk(clk), .rst_n(rst_n), .evt_pulse(evt), .reg_addr(addr), .reg_wr(wr),
        .reg_wdata(wdata), .reg_rdata(rdata), .wake_smi(w_smi), .wake_irq(w_irq),
        .wake_pwrup(w_pup), .wake_pwrbtn(w_pbt)
    );

    function automatic logic [3:0] ad(int bank, int kind);
        return 4'(bank * 8 + kind);
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wreg(int bank, int kind, logic [7:0] v);
        @(negedge clk);
        addr = ad(bank, kind); wdata = v; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rreg(int bank, int kind, output logic [7:0] v);
        @(negedge clk);
        addr = ad(bank, kind);
        #1 v = rdata;
    endtask

    task automatic pulse(logic [15:0] e);
        @(negedge clk);
        evt = e;
        @(negedge clk);
        evt = '0;
    endtask

    function automatic logic [7:0] wakes();
        return {4'h0, w_pbt, w_pup, w_irq, w_smi};
    endfunction

    task automatic clear_all();
        for (int b = 0; b < 2; b++) begin
            for (int k = 1; k < 8; k++) wreg(b, k, 8'h00);
            wreg(b, 0, 8'hFF);
        end
    endtask

    task automatic t_reset();
        logic [7:0] v;
        #1 chk("R1 wakes in reset", wakes(), 8'h00);
        @(negedge clk); rst_n = 1'b1;
        for (int b = 0; b < 2; b++)
            for (int k = 0; k < 8; k++) begin
                rreg(b, k, v);
                chk("R1 register after reset", v, 8'h00);
            end
        chk("R1 wakes after reset", wakes(), 8'h00);
    endtask

    task automatic t_regmap();
        logic [7:0] v;
        for (int b = 0; b < 2; b++)
            for (int k = 1; k < 8; k++) wreg(b, k, 8'(k * 16 + b * 3 + 1));
        for (int b = 0; b < 2; b++)
            for (int k = 1; k < 8; k++) begin
                rreg(b, k, v);
                chk("R10 readback", v, 8'(k * 16 + b * 3 + 1));
            end
        rreg(0, 0, v); chk("R10 status untouched by other writes", v, 8'h00);
        clear_all();
    endtask

    task automatic t_gate();
        logic [7:0] v;
        wreg(0, 4, 8'h20);
        pulse(16'h0020);
        rreg(0, 0, v); chk("R3 no enable ignored", v, 8'h00);
        chk("R3 no wake", wakes(), 8'h00);
        for (int k = 1; k <= 3; k++) begin
            wreg(0, k, 8'h20);
            pulse(16'h0020);
            rreg(0, 0, v); chk("R2 single enable latches", v, 8'h20);
            wreg(0, 0, 8'h20);
            wreg(0, k, 8'h00);
        end
        clear_all();
    endtask

    task automatic t_w1c();
        logic [7:0] v;
        wreg(0, 3, 8'h07);
        pulse(16'h0007);
        rreg(0, 0, v); chk("R2 three events", v, 8'h07);
        wreg(0, 0, 8'h00);
        rreg(0, 0, v); chk("R5 zero write no effect", v, 8'h07);
        wreg(0, 0, 8'h02);
        rreg(0, 0, v); chk("R5 one clears", v, 8'h05);
        repeat (40) @(negedge clk);
        rreg(0, 0, v); chk("R4 sticky", v, 8'h05);
        clear_all();
    endtask

    task automatic t_collision();
        logic [7:0] v;
        wreg(0, 1, 8'h01);
        pulse(16'h0001);
        @(negedge clk);
        evt = 16'h0001; addr = ad(0, 0); wdata = 8'h01; wr = 1'b1;
        @(negedge clk);
        evt = '0; wr = 1'b0;
        rreg(0, 0, v); chk("R6 pulse beats clear", v, 8'h01);
        wreg(0, 0, 8'h01);
        rreg(0, 0, v); chk("R5 clear after collision", v, 8'h00);
        clear_all();
    endtask

    task automatic t_multi();
        logic [7:0] v;
        wreg(1, 2, 8'h08);
        wreg(1, 4, 8'h08);
        wreg(1, 7, 8'h08);
        @(negedge clk); evt = 16'h0800;
        #1 chk("R7 no wake before edge", wakes(), 8'h00);
        @(negedge clk); evt = '0;
        #1 chk("R8 two outputs from one event", wakes(), 8'h09);
        rreg(1, 0, v); chk("R10 event 11 at bank1 bit3", v, 8'h08);
        wreg(1, 0, 8'h08);
        #1 chk("R7 wakes drop after clear", wakes(), 8'h00);
        clear_all();
    endtask

    task automatic t_hold();
        wreg(0, 1, 8'h04); wreg(1, 1, 8'h02);
        wreg(0, 5, 8'h04); wreg(1, 5, 8'h02);
        pulse(16'h0204);
        #1 chk("R7 irq from two sources", wakes(), 8'h02);
        wreg(0, 0, 8'h04);
        #1 chk("R9 held by remaining source", wakes(), 8'h02);
        wreg(1, 0, 8'h02);
        #1 chk("R9 released after last clear", wakes(), 8'h00);
        clear_all();
    endtask

    task automatic t_noroute();
        logic [7:0] v;
        wreg(1, 1, 8'h80);
        wreg(1, 6, 8'h40);
        pulse(16'h8000);
        rreg(1, 0, v); chk("R11 status set", v, 8'h80);
        chk("R11 unrouted event drives nothing", wakes(), 8'h00);
        clear_all();
    endtask

    initial begin
        t_reset();
        t_regmap();
        t_gate();
        t_w1c();
        t_collision();
        t_multi();
        t_hold();
        t_noroute();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule